// File: doc/BRIEF.md
# Serial-Loaded Twelve-Channel Trim Code Bank

This block holds twelve 8-bit trim codes, one per output channel. Each code would drive an external resistor-ladder converter. A host loads the codes over a three-wire serial link: a serial clock, an active-low select and a data line. While select is low, each rising serial-clock edge shifts one data bit into a 12-bit input register. When select returns high, the block splits the held word into a channel address and a code. It then writes that code into the addressed channel register.

The block runs in a single system clock domain. All three serial lines and the shutdown input pass through synchronizers before use. Serial edges are found by comparing successive synchronized samples, so the serial clock must be several times slower than the system clock.

A synchronous reset returns every channel to midscale. A shutdown input clears a per-channel drive-enable flag, which marks the outputs as open-circuited. Shutdown leaves the stored codes untouched.

Top module: `trim_bank_top`

## Requirements
- R1: While select is low, each rising serial-clock edge shifts the data line into the input register, MSB first, so the first bit of a frame ends up as word bit 11.
- R2: While select is high, serial-clock and data activity changes no register. A later empty select pulse therefore re-commits the previously held word.
- R3: Word bits 11..8 form the channel address and bits 7..0 form the code. Address value k (0..11) writes channel k, which appears on `chan_code[8k+7:8k]`.
- R4: When more than 12 bits arrive in one select-low window, only the last 12 bits received form the word.
- R5: The rising edge of select writes exactly one channel register. Channel registers change at no other time, except under reset.
- R6: Address values 12 to 15 write no channel, and every stored code keeps its value.
- R7: Reset loads every channel register with 0x80. Reset during an open frame discards the bits already shifted. A complete frame shifted after reset, in the same select-low window, is committed normally.
- R8: While shutdown is high, every bit of `chan_drive_en` is 0 and `shdn_active` is 1. While shutdown is low, every bit of `chan_drive_en` is 1.
- R9: Shutdown does not alter stored codes. Frames received during shutdown are still stored, and they show with drive enabled once shutdown is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_csn | input | 1 | Active-low frame select; its rising edge commits the word |
| ser_din | input | 1 | Serial data, MSB first |
| shdn | input | 1 | Shutdown request; outputs flagged open while high |
| chan_code | output | 96 | Twelve stored codes; channel k occupies bits 8k+7..8k |
| chan_drive_en | output | 12 | Per-channel drive enable, 0 means open-circuit |
| shdn_active | output | 1 | Registered, synchronized shutdown status |

## Verification
The assertions assume that the serial lines change slowly enough for every level to be seen across several system clocks. They also assume that data changes only while the serial clock is low, and that select rises only while the serial clock is high. The stimulus holds each serial-clock phase for three system clocks. It changes data only in the low phase and raises select only after a high phase, so no serial edge is missed or doubled. Reset is applied only with the serial clock high. This prevents the idle value restored in the synchronizers from creating a false edge.

// File: rtl/trim_pkg.sv
package trim_pkg;
  localparam int unsigned NUM_CH   = 12;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned CODE_W   = 8;
  localparam int unsigned SYNC_LEN = 2;

  function automatic logic [CODE_W-1:0] midscale();
    return CODE_W'(1) << (CODE_W - 1);
  endfunction
endpackage

// File: rtl/trim_sync_bit.sv
module trim_sync_bit #(
  parameter int unsigned STAGES = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= {STAGES{RST_VAL}};
    else     pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/trim_ser_rx.sv
module trim_ser_rx #(
  parameter int unsigned FRAME_W  = 12,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ser_clk,
  input  logic               ser_csn,
  input  logic               ser_din,
  output logic               commit,
  output logic [FRAME_W-1:0] word
);
  logic sclk_s, csn_s, din_s;
  logic sclk_d, csn_d;
  logic [FRAME_W-1:0] shreg;

  trim_sync_bit #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_sclk_sync (
    .clk(clk), .rst(rst), .d(ser_clk), .q(sclk_s));
  trim_sync_bit #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_csn_sync (
    .clk(clk), .rst(rst), .d(ser_csn), .q(csn_s));
  trim_sync_bit #(.STAGES(SYNC_LEN), .RST_VAL(1'b0)) u_din_sync (
    .clk(clk), .rst(rst), .d(ser_din), .q(din_s));

  wire sclk_rise = sclk_s & ~sclk_d;
  wire csn_rise  = csn_s & ~csn_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b1;
      csn_d  <= 1'b1;
      shreg  <= '0;
      commit <= 1'b0;
      word   <= '0;
    end else begin
      sclk_d <= sclk_s;
      csn_d  <= csn_s;
      commit <= csn_rise;
      if (csn_rise) word <= shreg;
      if (!csn_s && sclk_rise) shreg <= {shreg[FRAME_W-2:0], din_s};
    end
  end

  // R2
  csn_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> $stable(shreg));

  // R5
  commit_single_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit);
endmodule

// File: rtl/trim_chan_bank.sv
module trim_chan_bank #(
  parameter int unsigned NUM_CH = 12,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CODE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       commit,
  input  logic [ADDR_W+CODE_W-1:0]   word,
  output logic [NUM_CH*CODE_W-1:0]   codes
);
  localparam logic [CODE_W-1:0] MID  = trim_pkg::midscale();
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_CH - 1);

  logic [CODE_W-1:0] regs [NUM_CH];
  wire  [ADDR_W-1:0] addr = word[ADDR_W+CODE_W-1:CODE_W];
  wire  [CODE_W-1:0] code = word[CODE_W-1:0];
  wire               hit  = commit && (addr <= LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CH; i++) regs[i] <= MID;
    end else if (hit) begin
      regs[addr] <= code;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_flat
    assign codes[g*CODE_W +: CODE_W] = regs[g];
  end

  // R5
  no_commit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(codes));

  // R6
  bad_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && addr > LAST) |=> $stable(codes));

  // R7
  reset_mid_chk: assert property (@(posedge clk)
    rst |=> (codes == {NUM_CH{MID}}));
endmodule

// File: rtl/trim_drive_ctl.sv
module trim_drive_ctl #(
  parameter int unsigned NUM_CH   = 12,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shdn,
  output logic [NUM_CH-1:0] drive_en,
  output logic              shdn_active
);
  logic shdn_s;

  trim_sync_bit #(.STAGES(SYNC_LEN), .RST_VAL(1'b0)) u_shdn_sync (
    .clk(clk), .rst(rst), .d(shdn), .q(shdn_s));

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_en    <= '1;
      shdn_active <= 1'b0;
    end else begin
      drive_en    <= {NUM_CH{~shdn_s}};
      shdn_active <= shdn_s;
    end
  end

  // R8
  shdn_open_chk: assert property (@(posedge clk) disable iff (rst)
    shdn_s |=> (drive_en == '0 && shdn_active));

  // R8
  run_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !shdn_s |=> (drive_en == '1 && !shdn_active));
endmodule

// File: rtl/trim_bank_top.sv
module trim_bank_top #(
  parameter int unsigned NUM_CH   = trim_pkg::NUM_CH,
  parameter int unsigned ADDR_W   = trim_pkg::ADDR_W,
  parameter int unsigned CODE_W   = trim_pkg::CODE_W,
  parameter int unsigned SYNC_LEN = trim_pkg::SYNC_LEN
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ser_clk,
  input  logic                     ser_csn,
  input  logic                     ser_din,
  input  logic                     shdn,
  output logic [NUM_CH*CODE_W-1:0] chan_code,
  output logic [NUM_CH-1:0]        chan_drive_en,
  output logic                     shdn_active
);
  localparam int unsigned FRAME_W = ADDR_W + CODE_W;

  logic               commit;
  logic [FRAME_W-1:0] word;

  trim_ser_rx #(.FRAME_W(FRAME_W), .SYNC_LEN(SYNC_LEN)) u_rx (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_csn(ser_csn),
    .ser_din(ser_din), .commit(commit), .word(word));

  trim_chan_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_bank (
    .clk(clk), .rst(rst), .commit(commit), .word(word), .codes(chan_code));

  trim_drive_ctl #(.NUM_CH(NUM_CH), .SYNC_LEN(SYNC_LEN)) u_drive (
    .clk(clk), .rst(rst), .shdn(shdn), .drive_en(chan_drive_en),
    .shdn_active(shdn_active));
endmodule

// File: tb/trim_bank_top_bench.sv
`timescale 1ns/1ps
module trim_bank_top_bench;
  localparam int NCH = 12;
  localparam int HP  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b1, ser_csn = 1'b1, ser_din = 1'b0, shdn = 1'b0;
  logic [NCH*8-1:0] chan_code;
  logic [NCH-1:0]   chan_drive_en;
  logic             shdn_active;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] model [NCH];

  always #2 clk = ~clk;

  trim_bank_top u_trim_bank_top (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_csn(ser_csn),
    .ser_din(ser_din), .shdn(shdn), .chan_code(chan_code),
    .chan_drive_en(chan_drive_en), .shdn_active(shdn_active));

  task automatic wait_clks(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int k = 0; k < NCH; k++)
      check(chan_code[k*8 +: 8] === model[k], tag, {24'h0, chan_code[k*8 +: 8]},
            {24'h0, model[k]});
  endtask

  task automatic model_reset();
    for (int k = 0; k < NCH; k++) model[k] = 8'h80;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    wait_clks(3);
    rst = 1'b0;
    wait_clks(2);
    model_reset();
  endtask

  task automatic shift_bits(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_clk = 1'b0;
      ser_din = bits[i];
      wait_clks(HP);
      ser_clk = 1'b1;
      wait_clks(HP);
    end
  endtask

  task automatic open_frame();
    ser_csn = 1'b0;
    wait_clks(HP);
  endtask

  task automatic close_frame();
    ser_csn = 1'b1;
    wait_clks(8);
  endtask

  task automatic send(input logic [3:0] a, input logic [7:0] c);
    open_frame();
    shift_bits({20'h0, a, c}, 12);
    close_frame();
    if (a < NCH) model[a] = c;
  endtask

  task automatic t_reset_state();
    model_reset();
    check_all("R7 reset midscale");
    check(chan_drive_en === '1, "R8 drive on after reset", 32'(chan_drive_en), 32'hfff);
  endtask

  task automatic t_basic_writes();
    send(4'd0, 8'h12);
    send(4'd11, 8'hFE);
    send(4'd5, 8'h00);
    send(4'd7, 8'hFF);
    send(4'd3, 8'hA5);
    check_all("R1 R3 R5 basic writes");
  endtask

  task automatic t_overlong();
    open_frame();
    shift_bits(32'h1F, 5);
    shift_bits({20'h0, 4'd9, 8'h5A}, 12);
    close_frame();
    model[9] = 8'h5A;
    check_all("R4 overlong frame");
  endtask

  task automatic t_bad_addr();
    for (int a = 12; a < 16; a++) send(4'(a), 8'h77);
    check_all("R6 unused address");
  endtask

  task automatic t_cs_high_clocks();
    send(4'd6, 8'h3C);
    for (int i = 11; i >= 0; i--) begin
      ser_clk = 1'b0;
      ser_din = 1'(12'h1A5 >> i);
      wait_clks(HP);
      ser_clk = 1'b1;
      wait_clks(HP);
    end
    open_frame();
    close_frame();
    check_all("R2 clocks ignored while select high");
  endtask

  task automatic t_shutdown();
    shdn = 1'b1;
    wait_clks(5);
    check(chan_drive_en === '0, "R8 open during shutdown", 32'(chan_drive_en), 32'h0);
    check(shdn_active === 1'b1, "R8 shutdown status", 32'(shdn_active), 32'h1);
    check_all("R9 codes kept in shutdown");
    send(4'd2, 8'hC3);
    check_all("R9 write during shutdown");
    shdn = 1'b0;
    wait_clks(5);
    check(chan_drive_en === '1, "R8 drive restored", 32'(chan_drive_en), 32'hfff);
    check(shdn_active === 1'b0, "R8 status cleared", 32'(shdn_active), 32'h0);
    check_all("R9 codes after release");
  endtask

  task automatic t_mid_frame_reset();
    open_frame();
    shift_bits(32'h15, 5);
    rst = 1'b1;
    wait_clks(3);
    rst = 1'b0;
    wait_clks(2);
    model_reset();
    check_all("R7 reset during frame");
    shift_bits({20'h0, 4'd4, 8'h9C}, 12);
    close_frame();
    model[4] = 8'h9C;
    check_all("R7 frame after reset");
  endtask

  initial begin
    model_reset();
    do_reset();
    t_reset_state();
    t_basic_writes();
    t_overlong();
    t_bad_addr();
    t_cs_high_clocks();
    t_shutdown();
    t_mid_frame_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule